// File: doc/BRIEF.md
# Warp Fetch Eligibility Scheduler

This block decides, once per cycle, which warp may send its next instruction into a simple in-order SIMT pipeline. Each warp has one in-flight slot. A warp that has just been granted leaves arbitration until the pipeline reports that its instruction has retired. Warps that are still eligible keep being granted on the cycles in between, so the pipeline is filled from other warps while the busy ones wait.

A completion event carries a warp ID. It frees that warp's slot, and the warp can be granted again in the same cycle as its completion. A per-warp enable mask takes warps out of arbitration, for example when a warp has finished or is not yet launched. The pipeline-ready input stalls all grants. The arbitration is round-robin, starting after the warp granted last. A completion for a warp that has nothing in flight does not change the scheduling state. It sets an error flag that stays set until reset.

Top module: `warp_fetch_sched`

## Requirements
- R1: After reset no warp is in flight and the error flag is low. The first grant with every warp enabled and the pipeline ready goes to warp 0.
- R2: `fetch_valid` is high in a cycle exactly when `pipe_ready` is high and at least one warp is eligible. A warp is eligible when its `warp_enable` bit is 1 and it has no instruction in flight, after this cycle's completion has been applied.
- R3: The granted warp is the first eligible warp found when counting upward from the warp granted last plus one, wrapping from `NUM_WARPS-1` to 0.
- R4: A warp that has been granted is not granted again until a completion with its ID has been accepted. At most one instruction per warp is in flight.
- R5: When `pipe_ready` is low, or when no warp is eligible, no grant is made and the round-robin position does not move.
- R6: A completion for warp w that arrives in the same cycle w would otherwise be chosen makes w eligible in that cycle, and w can be granted in that cycle.
- R7: A warp whose `warp_enable` bit is 0 is never granted. A completion for such a warp is still accepted if that warp is in flight.
- R8: A completion for a warp with nothing in flight leaves the in-flight state and the round-robin position unchanged. It sets `err_flag` from the next cycle on, and only reset clears `err_flag`.
- R9: `fetch_warp` is `$clog2(NUM_WARPS)` bits wide and reads 0 in any cycle where `fetch_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_ready | input | 1 | Pipeline can accept an instruction this cycle |
| done_valid | input | 1 | A completion is reported this cycle |
| done_warp | input | $clog2(NUM_WARPS) | Warp ID of the completion |
| warp_enable | input | NUM_WARPS | Per-warp participation mask |
| fetch_valid | output | 1 | A warp is granted this cycle |
| fetch_warp | output | $clog2(NUM_WARPS) | ID of the granted warp |
| err_flag | output | 1 | Sticky flag for a completion without an in-flight instruction |

## Verification
The bench builds the scheduler with `NUM_WARPS=4`. At that size a two-bit ID and a four-bit mask let every enable pattern, every wrap point of the round-robin search, and every in-flight combination appear many times within a few thousand cycles. A sweep of the 16 enable masks, combined with stalls and legal completions that change every cycle, is compared against an arithmetic model of the requirements. Directed sequences cover the first grant after reset, the same-cycle completion-and-grant, stalls that hold the pointer, a spurious completion, and the clearing of the error flag by reset.

// File: rtl/wfs_pkg.sv
// Package: shared helpers for the warp fetch scheduler.
// Assumes: warp counts of at least 2.
package wfs_pkg;

    // Bits needed to number n warps.
    function automatic int unsigned id_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Next index in a ring of n entries.
    function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/wfs_inflight_table.sv
// Module: per-warp in-flight table.
// What it does: it holds one busy bit per warp. A legal completion clears the
// bit, and a grant sets it; a grant wins when both hit the same warp in one
// cycle. It reports the busy view after this cycle's completion, so the
// arbiter can grant a warp in its completion cycle. It flags a completion
// that has nothing to clear.
// Assumes: at most one completion and one grant per cycle.
module wfs_inflight_table #(
    parameter int unsigned NUM_WARPS = 8,
    parameter int unsigned ID_W      = wfs_pkg::id_bits(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_valid,
    input  logic [ID_W-1:0]      clr_warp,
    input  logic                 set_valid,
    input  logic [ID_W-1:0]      set_warp,
    output logic [NUM_WARPS-1:0] busy_eff,
    output logic                 spurious
);
    logic [NUM_WARPS-1:0] busy_q;
    logic [NUM_WARPS-1:0] clr_vec;
    logic [NUM_WARPS-1:0] set_vec;
    logic                 id_in_range;
    logic                 clr_hit;

    // Check that the completion ID names an existing warp.
    always_comb begin
        id_in_range = (32'(clr_warp) < NUM_WARPS);
    end

    // Decode the completion and the grant into one-hot vectors.
    generate
        for (genvar w = 0; w < NUM_WARPS; w++) begin : g_dec
            assign clr_vec[w] = clr_valid && (32'(clr_warp) == w) && busy_q[w];
            assign set_vec[w] = set_valid && (32'(set_warp) == w);
        end
    endgenerate

    // A completion counts as legal only if it clears a busy entry.
    always_comb begin
        clr_hit  = |clr_vec;
        spurious = clr_valid && !(id_in_range && clr_hit);
    end

    // Busy view after this cycle's completion (same-cycle bypass).
    always_comb begin
        busy_eff = busy_q & ~clr_vec;
    end

    // Update the table: the completion clears first, then the grant sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= (busy_q & ~clr_vec) | set_vec;
        end
    end

endmodule

// File: rtl/wfs_rr_arbiter.sv
// Module: round-robin picker with a remembered last grant.
// What it does: it searches upward from the last granted index plus one and
// wraps to 0. It grants only when enabled and when some request is set, and
// moves its pointer only on a grant.
// Assumes: after reset the last grant is NUM_WARPS-1, so index 0 goes first.
module wfs_rr_arbiter #(
    parameter int unsigned NUM_WARPS = 8,
    parameter int unsigned ID_W      = wfs_pkg::id_bits(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] req,
    input  logic                 go,
    output logic                 gnt_valid,
    output logic [ID_W-1:0]      gnt_idx
);
    localparam logic [ID_W-1:0] LAST_RESET = ID_W'(NUM_WARPS - 1);

    logic [ID_W-1:0] last_q;
    logic            found;
    logic [ID_W-1:0] pick;

    // Search for the first request after the last grant.
    always_comb begin
        int unsigned cand;
        found = 1'b0;
        pick  = '0;
        cand  = 32'(last_q);
        for (int k = 0; k < NUM_WARPS; k++) begin
            cand = wfs_pkg::ring_next(cand, NUM_WARPS);
            if (!found && req[cand]) begin
                found = 1'b1;
                pick  = ID_W'(cand);
            end
        end
    end

    // Drive the grant, with a zero index when there is no grant.
    always_comb begin
        gnt_valid = go && found;
        gnt_idx   = gnt_valid ? pick : '0;
    end

    // Remember the last granted index; hold it when there is no grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= LAST_RESET;
        end else if (gnt_valid) begin
            last_q <= pick;
        end
    end

endmodule

// File: rtl/wfs_err_flag.sv
// Module: sticky error bit.
// What it does: it sets on any cycle with the set input high and stays set
// until reset.
// Assumes: nothing beyond a synchronous reset.
module wfs_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic flag
);
    // Latch the error until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/warp_fetch_sched.sv
// Module: warp fetch eligibility scheduler (top).
// What it does: it grants one eligible warp per cycle into the pipeline.
// A warp is eligible when it is enabled and has no instruction in flight.
// The grant is taken off the busy view after this cycle's completion.
// Assumes: completions come from the pipeline, one per cycle at most.
module warp_fetch_sched #(
    parameter int unsigned NUM_WARPS = 8,
    parameter int unsigned ID_W      = wfs_pkg::id_bits(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pipe_ready,
    input  logic                 done_valid,
    input  logic [ID_W-1:0]      done_warp,
    input  logic [NUM_WARPS-1:0] warp_enable,
    output logic                 fetch_valid,
    output logic [ID_W-1:0]      fetch_warp,
    output logic                 err_flag
);
    logic [NUM_WARPS-1:0] busy_eff;
    logic [NUM_WARPS-1:0] eligible;
    logic                 spurious;

    // Eligible means enabled and not busy after this cycle's completion.
    always_comb begin
        eligible = warp_enable & ~busy_eff;
    end

    wfs_inflight_table #(.NUM_WARPS(NUM_WARPS), .ID_W(ID_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_valid(done_valid),
        .clr_warp (done_warp),
        .set_valid(fetch_valid),
        .set_warp (fetch_warp),
        .busy_eff (busy_eff),
        .spurious (spurious)
    );

    wfs_rr_arbiter #(.NUM_WARPS(NUM_WARPS), .ID_W(ID_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (eligible),
        .go       (pipe_ready),
        .gnt_valid(fetch_valid),
        .gnt_idx  (fetch_warp)
    );

    wfs_err_flag u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (spurious),
        .flag (err_flag)
    );

endmodule

// File: rtl/wfs_checker.sv
// Module: assertion checker for warp_fetch_sched, bound to the top.
// What it does: it keeps a shadow in-flight mask built from the ports only,
// and checks the grant rules against it.
// Assumes: it is attached through the bind statement at the end of the file.
module wfs_checker #(
    parameter int unsigned NUM_WARPS = 8,
    parameter int unsigned ID_W      = wfs_pkg::id_bits(NUM_WARPS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pipe_ready,
    input logic                 done_valid,
    input logic [ID_W-1:0]      done_warp,
    input logic [NUM_WARPS-1:0] warp_enable,
    input logic                 fetch_valid,
    input logic [ID_W-1:0]      fetch_warp,
    input logic                 err_flag
);
    logic [NUM_WARPS-1:0] shadow;
    logic                 frees_pick;

    // Track the in-flight set as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else begin
            if (done_valid) shadow[done_warp] <= 1'b0;
            if (fetch_valid) shadow[fetch_warp] <= 1'b1;
        end
    end

    // Note whether this cycle's completion frees the warp that is granted.
    always_comb begin
        frees_pick = done_valid && (done_warp == fetch_warp);
    end

    // R5
    no_grant_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> pipe_ready);

    // R7
    grant_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> warp_enable[fetch_warp]);

    // R4
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (!shadow[fetch_warp] || frees_pick));

    // R9
    idle_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (fetch_warp == '0));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(done_valid));

endmodule

bind warp_fetch_sched wfs_checker #(.NUM_WARPS(NUM_WARPS), .ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_ready (pipe_ready),
    .done_valid (done_valid),
    .done_warp  (done_warp),
    .warp_enable(warp_enable),
    .fetch_valid(fetch_valid),
    .fetch_warp (fetch_warp),
    .err_flag   (err_flag)
);

// File: tb/warp_fetch_sched_test.sv
// Bench: drives the scheduler with 4 warps and compares the outputs against
// an arithmetic model of the requirements.
module warp_fetch_sched_test;
    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pipe_ready = 1'b0;
    logic         done_valid = 1'b0;
    logic [W-1:0] done_warp = '0;
    logic [N-1:0] warp_enable = '0;
    logic         fetch_valid;
    logic [W-1:0] fetch_warp;
    logic         err_flag;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    bit [N-1:0] m_busy;
    int         m_last;
    bit         m_err;

    always #2 clk = ~clk;

    warp_fetch_sched #(.NUM_WARPS(N)) uut (
        .clk(clk), .rst_n(rst_n), .pipe_ready(pipe_ready),
        .done_valid(done_valid), .done_warp(done_warp),
        .warp_enable(warp_enable), .fetch_valid(fetch_valid),
        .fetch_warp(fetch_warp), .err_flag(err_flag)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pipe_ready = 0; done_valid = 0; done_warp = 0; warp_enable = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_busy = '0; m_last = N - 1; m_err = 0;
    endtask

    // One cycle: drive, compare against the model, then advance the model.
    task automatic step(input bit rdy, input bit dv, input int dw, input bit [N-1:0] en,
                        input string tag, output bit g_v, output int g_w);
        bit [N-1:0] clr;
        bit [N-1:0] elig;
        @(negedge clk);
        pipe_ready = rdy; done_valid = dv; done_warp = W'(dw); warp_enable = en;
        #1;
        clr = '0;
        if (dv && m_busy[dw]) clr[dw] = 1'b1;
        elig = en & ~(m_busy & ~clr);
        g_v = 0; g_w = 0;
        if (rdy) begin
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (m_last + k) % N;
                if (!g_v && elig[c]) begin g_v = 1; g_w = c; end
            end
        end
        check(tag, "fetch_valid", int'(fetch_valid), int'(g_v));
        check(tag, "fetch_warp", int'(fetch_warp), g_w);
        check(tag, "err_flag", int'(err_flag), int'(m_err));
        @(posedge clk);
        if (dv && !m_busy[dw]) m_err = 1;
        m_busy = m_busy & ~clr;
        if (g_v) begin m_busy[g_w] = 1'b1; m_last = g_w; end
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got 1 expected 0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit gv;
        int gw;
        do_reset();

        // R1: reset state, no grant while stalled, zero ID (R9)
        step(0, 0, 0, 4'hF, "R1", gv, gw);
        check("R9", "idle fetch_warp", int'(fetch_warp), 0);
        // R1 / R3: all warps granted in order 0..3
        for (int i = 0; i < N; i++) begin
            step(1, 0, 0, 4'hF, "R3", gv, gw);
            check("R1", "order id", gw, i);
        end
        // R4 / R5: all busy, no grant
        step(1, 0, 0, 4'hF, "R4", gv, gw);
        check("R5", "all busy valid", int'(gv), 0);
        // R6: complete warp 2 and grant it in the same cycle
        step(1, 1, 2, 4'hF, "R6", gv, gw);
        check("R6", "bypass grant id", gw, 2);
        // R5: completions under stall; pointer must stay at 2
        step(0, 1, 0, 4'hF, "R5", gv, gw);
        step(0, 1, 3, 4'hF, "R5", gv, gw);
        step(1, 0, 0, 4'hF, "R5", gv, gw);
        check("R5", "pointer held id", gw, 3);
        step(1, 0, 0, 4'hF, "R3", gv, gw);
        check("R3", "wrap id", gw, 0);
        // R7: warp 1 freed but disabled, must not be granted
        step(1, 1, 1, 4'b1101, "R7", gv, gw);
        check("R7", "disabled valid", int'(gv), 0);
        step(1, 0, 0, 4'b0010, "R7", gv, gw);
        check("R7", "re-enabled id", gw, 1);

        // Sweep: every enable mask, stalls, legal completions
        for (int cyc = 0; cyc < 4000; cyc++) begin
            bit [N-1:0] en;
            bit rdy, dv;
            int dw;
            en = 4'((cyc / 16) % 16);
            rdy = ($urandom % 4) != 0;
            dw = int'($urandom % N);
            dv = ($urandom % 2 == 1) && m_busy[dw];
            step(rdy, dv, dw, en, "R2", gv, gw);
        end

        // R8: a spurious completion leaves the state and sets the flag
        do_reset();
        step(1, 0, 0, 4'b0001, "R8", gv, gw);
        step(1, 1, 2, 4'b0110, "R8", gv, gw);
        check("R8", "grant after spurious", gw, 1);
        step(0, 0, 0, 4'b0110, "R8", gv, gw);
        check("R8", "err set", int'(err_flag), 1);
        for (int i = 0; i < 20; i++) begin
            step(1, 0, 0, 4'hF, "R8", gv, gw);
        end
        check("R8", "err sticky", int'(err_flag), 1);
        do_reset();
        step(0, 0, 0, 4'hF, "R8", gv, gw);
        check("R8", "err cleared by reset", int'(err_flag), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule